// File: doc/BRIEF.md
# Software-Loadable Device Chip Select

This block decides, once per bus cycle, whether one device on a shared multi-device bus takes part in that cycle. Two active-low hardware strobes select it directly. The first strobe is wired to every device in the system, so a cycle on it reaches all of them at once. The second strobe is private to this device. When neither strobe is active, a software path can select the device instead. A small selection register holds a disable bit and a target page number. The device answers when the disable bit is clear and the target equals the page number strapped on its pins.

Sampling is tied to the falling edge of the active-low bus enable `en_n`. The block sees `en_n` synchronously, so an edge is one clock in which `en_n` is low after a clock in which it was high. On that clock it evaluates the strobes against the current register contents and registers the decision on `dev_sel`. The decision is held until the next falling edge. The same evaluation also gates writes to the selection register. Software can therefore load every device through a global cycle on the shared strobe, address a single device by page, and later retarget or switch off the software path with another global write.

Top module: `dev_chip_select`

## Requirements
- R1: A falling edge of `en_n` with `cs1_n` low makes `dev_sel` high on the clock that follows that edge, whatever the register holds.
- R2: A falling edge of `en_n` with `cs2_n` low makes `dev_sel` high on the following clock, whatever the register holds.
- R3: After reset, `dev_sel` is low and `dsr_rdata` reads 0x0100: the disable bit (bit 8) is set and the target page (bits 3:0) is zero.
- R4: A falling edge with both strobes high, the disable bit (bit 8) clear and the target page (bits 3:0) equal to `page_strap` sets `dev_sel`. A target page that differs from `page_strap` clears it.
- R5: A falling edge with both strobes high and the disable bit (bit 8) set clears `dev_sel`, whatever target page is held.
- R6: `dev_sel` and the register change only on the clock after a falling edge of `en_n`. A clock with `en_n` held low or held high changes neither.
- R7: When `dsr_wr` is high at a falling edge and the device is selected by R1, R2 or R4, the register loads bit 8 and bits 3:0 of `dsr_wdata`. At a non-selected device, or without a falling edge, the write has no effect.
- R8: At a falling edge that also writes, the select decision uses the register contents from before the write.
- R9: Every register bit other than bit 8 and bits 3:0 reads as zero, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_n | input | 1 | Active-low bus enable; its falling edge is the sample point |
| cs1_n | input | 1 | Active-low strobe shared by all devices |
| cs2_n | input | 1 | Active-low strobe private to this device |
| page_strap | input | 4 | Fixed page number of this device |
| dsr_wr | input | 1 | Write request for the selection register in this bus cycle |
| dsr_wdata | input | 16 | Write data: bit 8 disable, bits 3:0 target page |
| dsr_rdata | output | 16 | Current selection register contents |
| dev_sel | output | 1 | Registered select decision |

## Verification
The bench writes a selection register with reserved bits set through a global cycle. A design that stored those bits would read them back non-zero. It retargets the page while the device is selected only through software. A design that evaluated the new contents in that same cycle would drop the select one cycle early. It holds `en_n` low across several clocks while the strobes and write request toggle. This exposes a design that samples on level instead of on the edge. It also writes at a device whose page does not match, which a design that ignored the select gate would accept.

// File: rtl/dsel_pkg.sv
package dsel_pkg;

    // Reason for the select decision evaluated at a sample edge.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_BCAST = 2'd1,
        SRC_LOCAL = 2'd2,
        SRC_SOFT = 2'd3
    } sel_src_e;

endpackage

// File: rtl/dsel_fall_det.sv
module dsel_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = en_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign fall = prev_q & ~en_n;
endmodule

// File: rtl/dsel_match.sv
module dsel_match
    import dsel_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic              cs1_n,
    input  logic              cs2_n,
    input  logic              soft_off,
    input  logic [PAGE_W-1:0] target,
    input  logic [PAGE_W-1:0] strap,
    output logic              hit
);
    logic [PAGE_W-1:0] bit_eq;
    sel_src_e          src;

    for (genvar i = 0; i < PAGE_W; i++) begin : g_cmp
        assign bit_eq[i] = ~(target[i] ^ strap[i]);
    end

    always_comb begin
        if (!cs1_n) begin
            src = SRC_BCAST;
        end else if (!cs2_n) begin
            src = SRC_LOCAL;
        end else if (!soft_off && (&bit_eq)) begin
            src = SRC_SOFT;
        end else begin
            src = SRC_NONE;
        end
        hit = (src != SRC_NONE);
    end
endmodule

// File: rtl/dev_chip_select.sv
module dev_chip_select #(
    parameter int DATA_W  = 16,
    parameter int PAGE_W  = 4,
    parameter int OFF_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              cs1_n,
    input  logic              cs2_n,
    input  logic [PAGE_W-1:0] page_strap,
    input  logic              dsr_wr,
    input  logic [DATA_W-1:0] dsr_wdata,
    output logic [DATA_W-1:0] dsr_rdata,
    output logic              dev_sel
);
    localparam logic [DATA_W-1:0] PAGE_MASK = DATA_W'((1 << PAGE_W) - 1);
    localparam logic [DATA_W-1:0] OFF_MASK  = DATA_W'(1) << OFF_BIT;
    localparam logic [DATA_W-1:0] KEEP_MASK = PAGE_MASK | OFF_MASK;
    localparam logic [DATA_W-1:0] RST_WORD  = OFF_MASK;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              sel;
    } state_t;

    state_t st_d, st_q;
    logic   fall;
    logic   hit;

    dsel_fall_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .en_n  (en_n),
        .fall  (fall)
    );

    dsel_match #(.PAGE_W(PAGE_W)) u_match (
        .cs1_n    (cs1_n),
        .cs2_n    (cs2_n),
        .soft_off (st_q.word[OFF_BIT]),
        .target   (st_q.word[PAGE_W-1:0]),
        .strap    (page_strap),
        .hit      (hit)
    );

    always_comb begin
        st_d = st_q;
        if (fall) begin
            st_d.sel = hit;
            if (dsr_wr && hit) begin
                st_d.word = dsr_wdata & KEEP_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= RST_WORD;
            st_q.sel  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dsr_rdata = st_q.word;
    assign dev_sel   = st_q.sel;
endmodule

// File: rtl/dsel_chk.sv
module dsel_chk #(
    parameter int DATA_W  = 16,
    parameter int PAGE_W  = 4,
    parameter int OFF_BIT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_n,
    input logic              cs1_n,
    input logic              cs2_n,
    input logic [PAGE_W-1:0] page_strap,
    input logic [DATA_W-1:0] dsr_rdata,
    input logic              dev_sel
);
    localparam logic [DATA_W-1:0] KEEP = DATA_W'((1 << PAGE_W) - 1) | (DATA_W'(1) << OFF_BIT);

    logic en_seen;
    logic edge_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_seen <= 1'b1;
        else        en_seen <= en_n;
    end
    assign edge_now = en_seen && !en_n;

    AST_HW_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && !cs1_n) |=> dev_sel); // R1
    AST_HW_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && !cs2_n) |=> dev_sel); // R2
    AST_SOFT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && cs1_n && cs2_n && !dsr_rdata[OFF_BIT]
         && dsr_rdata[PAGE_W-1:0] == page_strap) |=> dev_sel); // R4
    AST_SOFT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && cs1_n && cs2_n && dsr_rdata[OFF_BIT]) |=> !dev_sel); // R5
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_now |=> $stable(dev_sel)); // R6
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_now |=> $stable(dsr_rdata)); // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dsr_rdata & ~KEEP) == '0); // R9
endmodule

bind dev_chip_select dsel_chk #(
    .DATA_W  (DATA_W),
    .PAGE_W  (PAGE_W),
    .OFF_BIT (OFF_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_n       (en_n),
    .cs1_n      (cs1_n),
    .cs2_n      (cs2_n),
    .page_strap (page_strap),
    .dsr_rdata  (dsr_rdata),
    .dev_sel    (dev_sel)
);

// File: tb/sim_dev_chip_select.sv
module sim_dev_chip_select;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] STRAP = 4'hA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_n = 1'b1;
    logic        cs1_n = 1'b1;
    logic        cs2_n = 1'b1;
    logic        dsr_wr = 1'b0;
    logic [15:0] dsr_wdata = '0;
    logic [15:0] dsr_rdata;
    logic        dev_sel;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Behavioural reference state
    int m_off = 1;
    int m_page = 0;
    int m_sel = 0;
    int m_prev_en = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dev_chip_select u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_n       (en_n),
        .cs1_n      (cs1_n),
        .cs2_n      (cs2_n),
        .page_strap (STRAP),
        .dsr_wr     (dsr_wr),
        .dsr_wdata  (dsr_wdata),
        .dsr_rdata  (dsr_rdata),
        .dev_sel    (dev_sel)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int model_word();
        return (m_off << 8) | m_page;
    endfunction

    // One bus clock: drive at negedge, advance model, compare at next negedge.
    task automatic cyc(input bit e, input bit c1, input bit c2, input bit w,
                       input logic [15:0] d, input string tag);
        bit fall;
        bit hit;
        en_n = e; cs1_n = c1; cs2_n = c2; dsr_wr = w; dsr_wdata = d;
        fall = (m_prev_en == 1) && (e == 0);
        hit = !c1 || !c2 || (m_off == 0 && m_page == int'(STRAP));
        if (fall) begin
            m_sel = hit ? 1 : 0;
            if (w && hit) begin
                m_off = int'(d[8]);
                m_page = int'(d[3:0]);
            end
        end
        m_prev_en = e;
        @(posedge clk);
        @(negedge clk);
        check(tag, int'(dev_sel), m_sel, "dev_sel");
        check(tag, int'(dsr_rdata), model_word(), "dsr_rdata");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R3", int'(dev_sel), 0, "dev_sel in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R3", int'(dev_sel), 0, "dev_sel after reset");
        check("R3", int'(dsr_rdata), 16'h0100, "dsr_rdata after reset");

        // Software path disabled after reset: no select.
        cyc(0, 1, 1, 0, 16'h0, "R5");
        cyc(1, 1, 1, 0, 16'h0, "R6");
        // Shared strobe
        cyc(0, 0, 1, 0, 16'h0, "R1");
        // en_n held low, strobes drop away and write attempted: nothing moves
        cyc(0, 1, 1, 1, 16'h000A, "R6");
        cyc(1, 1, 1, 0, 16'h0, "R6");
        cyc(0, 1, 1, 0, 16'h0, "R5");
        cyc(1, 1, 1, 0, 16'h0, "R6");
        // Private strobe
        cyc(0, 1, 0, 0, 16'h0, "R2");
        cyc(1, 1, 1, 0, 16'h0, "R6");
        // Global write enabling software select, reserved bits set
        cyc(0, 0, 1, 1, 16'hFE0A, "R9");
        cyc(1, 1, 1, 0, 16'h0, "R7");
        // Software hit
        cyc(0, 1, 1, 0, 16'h0, "R4");
        cyc(1, 1, 1, 0, 16'h0, "R6");
        // Retarget while selected by software: old contents decide
        cyc(0, 1, 1, 1, 16'h0005, "R8");
        cyc(1, 1, 1, 0, 16'h0, "R6");
        // Page mismatch
        cyc(0, 1, 1, 0, 16'h0, "R4");
        cyc(1, 1, 1, 0, 16'h0, "R6");
        // Write at a non-selected device is dropped
        cyc(0, 1, 1, 1, 16'h000A, "R7");
        cyc(1, 1, 1, 1, 16'h000A, "R7");
        // Private strobe overrides mismatch and permits a write
        cyc(0, 1, 0, 1, 16'h000A, "R7");
        cyc(1, 1, 1, 0, 16'h0, "R6");
        cyc(0, 1, 1, 0, 16'h0, "R4");
        cyc(1, 1, 1, 0, 16'h0, "R6");
        // Global write turns software select off
        cyc(0, 0, 1, 1, 16'h010A, "R5");
        cyc(1, 1, 1, 0, 16'h0, "R6");
        cyc(0, 1, 1, 0, 16'h0, "R5");
        cyc(1, 1, 1, 0, 16'h0, "R6");
        // Shared strobe still works with software off
        cyc(0, 0, 1, 0, 16'h0, "R1");
        cyc(1, 1, 1, 0, 16'h0, "R6");
        finish_run();
    end
endmodule